// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block holds the program counter of a single-cycle core that fetches one 32-bit instruction per clock, and it chooses the address of the following instruction. Each cycle it produces four candidate addresses: the sequential successor, a PC-relative branch destination, a pseudo-absolute jump destination built from a 26-bit target field, and a register-supplied address for indirect jumps. A fixed priority picks one of them, and the PC register loads it on the next rising clock edge. The instruction decoder and the ALU supply the control inputs: a branch request, a flag that inverts the branch sense, the ALU equality (zero) flag, a jump request and a jump-through-register request.

The current PC drives the instruction-memory address directly. The sequential successor is also brought out without a register, so that a jump-and-link can write the return address into the link register in the same cycle. All pins are plain control and data signals. The block has no streaming interface and no back-pressure, because the PC advances on every clock edge.

Top module: `pcu_fetch_next`

## Requirements
- R1: While the synchronous, active-high reset `rst` is high at a rising clock edge, the PC loads 0x0000_0000 at that edge, whatever the request inputs are.
- R2: When no transfer is selected, the PC becomes PC+4 at the next rising edge, wrapping modulo 2^32.
- R3: The branch destination is (PC+4) plus the 16-bit immediate `imm_i`, sign-extended from bit 15 and shifted left by two bits, wrapping modulo 2^32.
- R4: With `br_req`=1 and `br_ne`=0 (equal-compare branch), the branch is taken only when `alu_zero`=1.
- R5: With `br_req`=1 and `br_ne`=1 (not-equal branch), the branch is taken only when `alu_zero`=0. When `br_req`=0, `br_ne` and `alu_zero` have no effect on the next PC.
- R6: The jump destination is {PC[31:28], `jtgt_i`[25:0], 2'b00}. The upper four bits come from the current PC, not from PC+4.
- R7: When `jreg_req`=1, the next PC is the 32-bit value on `reg_val_i`, taken as it is.
- R8: When several requests are active, the priority is register jump, then `jmp_req`, then a taken branch, then sequential.
- R9: `pc_plus4_o` equals `pc_o`+4 (mod 2^32) combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imm_i | input | 16 | Branch offset field of the current instruction |
| jtgt_i | input | 26 | Jump target field of the current instruction |
| br_req | input | 1 | Current instruction is a conditional branch |
| br_ne | input | 1 | Branch takes the not-equal sense |
| alu_zero | input | 1 | ALU result is zero (operands equal) |
| jmp_req | input | 1 | Pseudo-absolute jump (including jump-and-link) |
| jreg_req | input | 1 | Jump to register value |
| reg_val_i | input | 32 | Register operand for the register jump |
| pc_o | output | 32 | Current PC / instruction-memory address |
| pc_plus4_o | output | 32 | PC+4, the link value |

## Verification
All 32 combinations of the five control inputs are applied from several starting PCs. Among these starts are 0xFFFF_FFFC, where the sequential wrap to zero shows up, and an address whose upper nibble differs from that of PC+4, which separates the current-PC region from the PC+4 region in a jump. Each combination is paired with the immediates 0, +1, -1, 0x7FFF and 0x8000, which catch a zero-extension or unshifted offset and an off-by-one in the sign bit. Because the sweep covers every overlap of requests, it also confirms the priority order and that the branch sense flags are ignored when no branch is requested. Reset is asserted while every request is active to show that it takes precedence.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_JMP = 2'd2,
    SRC_REG = 2'd3
  } next_src_e;
endpackage

// File: rtl/pcu_target_calc.sv
module pcu_target_calc #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int TW = 26
) (
  input  logic [AW-1:0] pc,
  input  logic [IW-1:0] imm,
  input  logic [TW-1:0] jtgt,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] br_addr,
  output logic [AW-1:0] jmp_addr
);
  localparam int RW = AW - TW - 2;   // region bits kept from the PC
  localparam int XW = AW - IW;       // sign-extension width

  logic [AW-1:0] imm_ext;
  logic [AW-1:0] imm_word;

  assign seq_addr = pc + AW'(4);
  assign imm_ext  = {{XW{imm[IW-1]}}, imm};
  assign imm_word = {imm_ext[AW-3:0], 2'b00};
  assign br_addr  = seq_addr + imm_word;

  generate
    if (RW > 0) begin : g_region
      assign jmp_addr = {pc[AW-1 -: RW], jtgt, 2'b00};
    end else begin : g_noregion
      assign jmp_addr = {jtgt[AW-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
  import pcu_pkg::*;
(
  input  logic      br_req,
  input  logic      br_ne,
  input  logic      alu_zero,
  input  logic      jmp_req,
  input  logic      jreg_req,
  output next_src_e src
);
  logic br_taken;

  always_comb begin
    if (br_ne) br_taken = br_req & ~alu_zero;
    else       br_taken = br_req &  alu_zero;
  end

  always_comb begin
    if (jreg_req)      src = SRC_REG;
    else if (jmp_req)  src = SRC_JMP;
    else if (br_taken) src = SRC_BR;
    else               src = SRC_SEQ;
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int          AW         = 32,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= AW'(RESET_ADDR);
    else     q <= d;
  end
endmodule

// File: rtl/pcu_fetch_next.sv
module pcu_fetch_next
  import pcu_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          IW         = 16,
  parameter int          TW         = 26,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] imm_i,
  input  logic [TW-1:0] jtgt_i,
  input  logic          br_req,
  input  logic          br_ne,
  input  logic          alu_zero,
  input  logic          jmp_req,
  input  logic          jreg_req,
  input  logic [AW-1:0] reg_val_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] pc_plus4_o
);
  logic [AW-1:0] pc_q;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] br_addr;
  logic [AW-1:0] jmp_addr;
  logic [AW-1:0] next_pc;
  next_src_e     src;

  pcu_target_calc #(.AW(AW), .IW(IW), .TW(TW)) u_calc (
    .pc       (pc_q),
    .imm      (imm_i),
    .jtgt     (jtgt_i),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  pcu_next_sel u_sel (
    .br_req   (br_req),
    .br_ne    (br_ne),
    .alu_zero (alu_zero),
    .jmp_req  (jmp_req),
    .jreg_req (jreg_req),
    .src      (src)
  );

  always_comb begin
    unique case (src)
      SRC_REG: next_pc = reg_val_i;
      SRC_JMP: next_pc = jmp_addr;
      SRC_BR:  next_pc = br_addr;
      default: next_pc = seq_addr;
    endcase
  end

  pcu_pc_reg #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk (clk),
    .rst (rst),
    .d   (next_pc),
    .q   (pc_q)
  );

  assign pc_o       = pc_q;
  assign pc_plus4_o = seq_addr;
endmodule

// File: rtl/pcu_fetch_next_chk.sv
module pcu_fetch_next_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] imm_i,
  input logic [25:0] jtgt_i,
  input logic        br_req,
  input logic        br_ne,
  input logic        alu_zero,
  input logic        jmp_req,
  input logic        jreg_req,
  input logic [31:0] reg_val_i,
  input logic [31:0] pc_o,
  input logic [31:0] pc_plus4_o
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: a reset edge leaves the PC at zero
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_zero: assert (pc_o == 32'h0) else $error("R1 reset value");
    end
  end

  // R9: link output tracks the PC in the same cycle
  always @(negedge clk) begin
    if (rst_q === 1'b0) begin
      a_r9_link_value: assert (pc_plus4_o == pc_o + 32'd4) else $error("R9 link");
    end
  end

  a_r7_reg_jump: assert property (@(posedge clk) disable iff (rst)
    jreg_req |=> pc_o == $past(reg_val_i));

  a_r6_jump_region: assert property (@(posedge clk) disable iff (rst)
    (!jreg_req && jmp_req) |=> pc_o == {$past(pc_o[31:28]), $past(jtgt_i), 2'b00});

  a_r4_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (!jreg_req && !jmp_req && br_req && !br_ne && alu_zero)
      |=> pc_o == $past(pc_o) + 32'd4 + {{14{$past(imm_i[15])}}, $past(imm_i), 2'b00});

  a_r5_bne_taken: assert property (@(posedge clk) disable iff (rst)
    (!jreg_req && !jmp_req && br_req && br_ne && !alu_zero)
      |=> pc_o == $past(pc_o) + 32'd4 + {{14{$past(imm_i[15])}}, $past(imm_i), 2'b00});

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jreg_req && !jmp_req && (!br_req || (br_ne == alu_zero)))
      |=> pc_o == $past(pc_o) + 32'd4);
endmodule

bind pcu_fetch_next pcu_fetch_next_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .imm_i      (imm_i),
  .jtgt_i     (jtgt_i),
  .br_req     (br_req),
  .br_ne      (br_ne),
  .alu_zero   (alu_zero),
  .jmp_req    (jmp_req),
  .jreg_req   (jreg_req),
  .reg_val_i  (reg_val_i),
  .pc_o       (pc_o),
  .pc_plus4_o (pc_plus4_o)
);

// File: tb/pcu_fetch_next_bench.sv
module pcu_fetch_next_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] imm_i;
  logic [25:0] jtgt_i;
  logic        br_req, br_ne, alu_zero, jmp_req, jreg_req;
  logic [31:0] reg_val_i;
  logic [31:0] pc_o, pc_plus4_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pcu_fetch_next u_pcu_fetch_next (
    .clk (clk), .rst (rst), .imm_i (imm_i), .jtgt_i (jtgt_i),
    .br_req (br_req), .br_ne (br_ne), .alu_zero (alu_zero),
    .jmp_req (jmp_req), .jreg_req (jreg_req), .reg_val_i (reg_val_i),
    .pc_o (pc_o), .pc_plus4_o (pc_plus4_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    br_req = 0; br_ne = 0; alu_zero = 0; jmp_req = 0; jreg_req = 0;
  endtask

  function automatic logic [31:0] model(input logic [31:0] pc, input int c,
                                        input logic [15:0] im, input logic [25:0] tg,
                                        input logic [31:0] rv, output string tag);
    logic jr, j, b, ne, z;
    longint off;
    jr = c[4]; j = c[3]; b = c[2]; ne = c[1]; z = c[0];
    off = longint'($signed(im)) * 4;
    if (jr) begin tag = "R7/R8"; return rv; end
    if (j) begin
      tag = "R6/R8";
      return (pc & 32'hF000_0000) | (32'(tg) * 4);
    end
    if (b && !ne && z) begin tag = "R3/R4"; return 32'(longint'(pc) + 4 + off); end
    if (b && ne && !z) begin tag = "R3/R5"; return 32'(longint'(pc) + 4 + off); end
    tag = (b ? "R2/R4/R5" : "R2/R5");
    return 32'(longint'(pc) + 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] starts [3];
    logic [15:0] imms [5];
    string tag;
    logic [31:0] exp;
    starts[0] = 32'h0000_1000; starts[1] = 32'h1FFF_FFFC; starts[2] = 32'hFFFF_FFFC;
    imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'hFFFF;
    imms[3] = 16'h7FFF; imms[4] = 16'h8000;

    idle();
    rst = 1; imm_i = 0; jtgt_i = 0; reg_val_i = 0;
    step(); step();
    chk("R1 reset value", pc_o, 32'h0);
    chk("R9 link after reset", pc_plus4_o, 32'h4);
    rst = 0;
    step();
    chk("R2 first advance", pc_o, 32'h4);

    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 5; m++) begin
        for (int c = 0; c < 32; c++) begin
          idle(); jreg_req = 1; reg_val_i = starts[s];
          step();
          idle();
          imm_i = imms[m];
          jtgt_i = 26'h2AB_CDEF ^ 26'(m * 26'h0123_457);
          reg_val_i = 32'hA5A5_0000 | 32'(c * 4 + m);
          jreg_req = c[4]; jmp_req = c[3]; br_req = c[2]; br_ne = c[1]; alu_zero = c[0];
          chk("R9 link value", pc_plus4_o, starts[s] + 32'd4);
          exp = model(starts[s], c, imm_i, jtgt_i, reg_val_i, tag);
          step();
          chk(tag, pc_o, exp);
        end
      end
    end

    // R1: reset overrides every request
    br_req = 1; br_ne = 0; alu_zero = 1; jmp_req = 1; jreg_req = 1;
    reg_val_i = 32'h1234_5678; rst = 1;
    step();
    chk("R1 reset priority", pc_o, 32'h0);
    rst = 0; idle();
    step();
    chk("R2 after reset", pc_o, 32'h4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule